// File: doc/BRIEF.md
# Elevator Car Controller with Fire Override

This block controls one elevator car. Each cycle it compares the target floor (already chosen by a separate request-selection stage) with the floor the car is on. It commands the car up or down until the two match. It then holds the door open for a minimum dwell, counted in one-second ticks, and afterwards waits in a rest state for a new target. All outputs are decoded from the state register alone, so every output changes one clock after the state changes.

A fire alarm input overrides normal service from any normal state. The car is driven down to the base floor (floor 1), where the door opens. The door stays open while the alarm is held. Normal service resumes at the rest state only after the car has reached the base floor with its door open and the alarm has been released. Releasing the alarm during the descent does not stop the descent.

The states are: REST (idle, door open, waiting), RISE (moving up), SINK (moving down), DWELL (door held open while the dwell counter runs), FIRE_SINK (emergency descent) and FIRE_DOOR (emergency door open at the base floor).

Top module: `lift_car_ctrl`

## Requirements
- R1: After reset the controller is in REST with the dwell counter at zero, so the outputs {move_up, move_down, door_open, dwell_start} read 0,0,1,0.
- R2: Outputs per state as {move_up, move_down, door_open, dwell_start}: REST 0,0,1,0; RISE 1,0,0,0; SINK 0,1,0,0; DWELL 0,0,1,1; FIRE_SINK 0,1,0,0; FIRE_DOOR 0,0,1,0.
- R3: From REST, the next state is RISE when req_floor > cur_floor, SINK when req_floor < cur_floor, and REST when they are equal.
- R4: RISE is kept while req_floor > cur_floor and is otherwise left for DWELL. SINK is kept while req_floor < cur_floor and is otherwise left for DWELL.
- R5: On entry to DWELL the dwell counter is zero. It counts sec_tick pulses while in DWELL and saturates at DWELL_SECS (default 10). DWELL is left for REST on the first clock edge at which the count equals DWELL_SECS. Ticks outside DWELL have no effect.
- R6: door_open is never high in the same cycle as move_up or move_down, and move_up and move_down are never high together.
- R7: fire_alarm high in REST, RISE, SINK or DWELL moves the controller to FIRE_SINK at the next clock edge. Fire has priority over every normal transition.
- R8: FIRE_SINK is kept while cur_floor > 1, whether or not fire_alarm is still high, and is left for FIRE_DOOR when cur_floor <= 1.
- R9: FIRE_DOOR is kept while fire_alarm is high and moves to REST on the first clock edge at which fire_alarm is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_floor | input | FLOOR_W | Target floor from the request-selection stage |
| cur_floor | input | FLOOR_W | Floor the car is currently at |
| fire_alarm | input | 1 | Fire emergency request |
| sec_tick | input | 1 | One-cycle pulse once per second |
| move_up | output | 1 | Drive the car upward |
| move_down | output | 1 | Drive the car downward |
| door_open | output | 1 | Open the door |
| dwell_start | output | 1 | High while the dwell timer is running |

## Verification
The dwell boundary is probed tick by tick. A counter that is off by one would release the door one tick early or late. A counter that is not cleared on entry would release it at once on a second visit. The bench drops the alarm halfway through the emergency descent; a design that returned to normal service there would move the car or open the door away from the base floor. Raising the alarm while the car is already at floor 1, and in every normal state, shows whether fire really has priority; a design that gave the dwell or motion transitions precedence would ignore the alarm for a cycle or more. Long runs of random targets, floors and alarms are checked against a cycle model in the bench.

// File: rtl/lift_pkg.sv
package lift_pkg;

    typedef enum logic [2:0] {
        ST_REST      = 3'd0,
        ST_RISE      = 3'd1,
        ST_SINK      = 3'd2,
        ST_DWELL     = 3'd3,
        ST_FIRE_SINK = 3'd4,
        ST_FIRE_DOOR = 3'd5
    } lift_state_t;

    typedef struct packed {
        logic up;
        logic down;
        logic door;
        logic start;
    } lift_drive_t;

endpackage

// File: rtl/lift_floor_cmp.sv
module lift_floor_cmp #(
    parameter int FLOOR_W    = 4,
    parameter int BASE_FLOOR = 1
) (
    input  logic [FLOOR_W-1:0] req_floor,
    input  logic [FLOOR_W-1:0] cur_floor,
    output logic               req_above,
    output logic               req_below,
    output logic               above_base
);
    localparam logic [FLOOR_W-1:0] BASE_V = FLOOR_W'(BASE_FLOOR);

    always_comb begin
        req_above  = req_floor > cur_floor;
        req_below  = req_floor < cur_floor;
        above_base = cur_floor > BASE_V;
    end
endmodule

// File: rtl/lift_dwell_timer.sv
module lift_dwell_timer #(
    parameter int DWELL_SECS = 10,
    localparam int CNT_W     = $clog2(DWELL_SECS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    output logic [CNT_W-1:0] count,
    output logic             done
);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(DWELL_SECS);

    always_comb done = (count == LIMIT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (!run) begin
            count <= '0;
        end else if (tick && !done) begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/lift_ctrl_fsm.sv
module lift_ctrl_fsm
    import lift_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_above,
    input  logic        req_below,
    input  logic        above_base,
    input  logic        fire,
    input  logic        dwell_done,
    output lift_state_t state_q,
    output lift_drive_t drive
);
    lift_state_t state_d;
    logic        in_normal;

    always_comb begin
        in_normal = (state_q == ST_REST) || (state_q == ST_RISE) ||
                    (state_q == ST_SINK) || (state_q == ST_DWELL);
    end

    // next-state selection; fire preempts every normal state
    always_comb begin
        state_d = state_q;
        if (fire && in_normal) begin
            state_d = ST_FIRE_SINK;
        end else begin
            unique case (state_q)
                ST_REST: begin
                    if (req_above)      state_d = ST_RISE;
                    else if (req_below) state_d = ST_SINK;
                    else                state_d = ST_REST;
                end
                ST_RISE:      state_d = req_above ? ST_RISE : ST_DWELL;
                ST_SINK:      state_d = req_below ? ST_SINK : ST_DWELL;
                ST_DWELL:     state_d = dwell_done ? ST_REST : ST_DWELL;
                ST_FIRE_SINK: state_d = above_base ? ST_FIRE_SINK : ST_FIRE_DOOR;
                ST_FIRE_DOOR: state_d = fire ? ST_FIRE_DOOR : ST_REST;
                default:      state_d = ST_REST;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_REST;
        else        state_q <= state_d;
    end

    // Moore output decode
    always_comb begin
        drive = '0;
        unique case (state_q)
            ST_REST:      drive = '{up: 1'b0, down: 1'b0, door: 1'b1, start: 1'b0};
            ST_RISE:      drive = '{up: 1'b1, down: 1'b0, door: 1'b0, start: 1'b0};
            ST_SINK:      drive = '{up: 1'b0, down: 1'b1, door: 1'b0, start: 1'b0};
            ST_DWELL:     drive = '{up: 1'b0, down: 1'b0, door: 1'b1, start: 1'b1};
            ST_FIRE_SINK: drive = '{up: 1'b0, down: 1'b1, door: 1'b0, start: 1'b0};
            ST_FIRE_DOOR: drive = '{up: 1'b0, down: 1'b0, door: 1'b1, start: 1'b0};
            default:      drive = '0;
        endcase
    end
endmodule

// File: rtl/lift_car_ctrl.sv
module lift_car_ctrl
    import lift_pkg::*;
#(
    parameter int FLOOR_W    = 4,
    parameter int DWELL_SECS = 10,
    parameter int BASE_FLOOR = 1,
    localparam int CNT_W     = $clog2(DWELL_SECS + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [FLOOR_W-1:0] req_floor,
    input  logic [FLOOR_W-1:0] cur_floor,
    input  logic               fire_alarm,
    input  logic               sec_tick,
    output logic               move_up,
    output logic               move_down,
    output logic               door_open,
    output logic               dwell_start
);
    logic             req_above;
    logic             req_below;
    logic             above_base;
    logic             dwell_done;
    logic [CNT_W-1:0] dwell_cnt;
    lift_state_t      state_q;
    lift_drive_t      drive;

    lift_floor_cmp #(
        .FLOOR_W   (FLOOR_W),
        .BASE_FLOOR(BASE_FLOOR)
    ) cmp_i (
        .req_floor (req_floor),
        .cur_floor (cur_floor),
        .req_above (req_above),
        .req_below (req_below),
        .above_base(above_base)
    );

    lift_dwell_timer #(
        .DWELL_SECS(DWELL_SECS)
    ) timer_i (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (state_q == ST_DWELL),
        .tick (sec_tick),
        .count(dwell_cnt),
        .done (dwell_done)
    );

    lift_ctrl_fsm fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_above (req_above),
        .req_below (req_below),
        .above_base(above_base),
        .fire      (fire_alarm),
        .dwell_done(dwell_done),
        .state_q   (state_q),
        .drive     (drive)
    );

    always_comb begin
        move_up     = drive.up;
        move_down   = drive.down;
        door_open   = drive.door;
        dwell_start = drive.start;
    end
endmodule

// File: rtl/lift_car_ctrl_chk.sv
module lift_car_ctrl_chk
    import lift_pkg::*;
#(
    parameter int FLOOR_W    = 4,
    parameter int DWELL_SECS = 10,
    parameter int BASE_FLOOR = 1,
    localparam int CNT_W     = $clog2(DWELL_SECS + 1)
) (
    input logic               clk,
    input logic               rst_n,
    input logic [FLOOR_W-1:0] cur_floor,
    input logic               fire_alarm,
    input logic               move_up,
    input logic               move_down,
    input logic               door_open,
    input logic               dwell_start,
    input lift_state_t        state_q,
    input logic [CNT_W-1:0]   dwell_cnt
);
    localparam logic [FLOOR_W-1:0] BASE_V = FLOOR_W'(BASE_FLOOR);
    localparam logic [CNT_W-1:0]   LIMIT  = CNT_W'(DWELL_SECS);

    a_r6_door_shut_in_motion: assert property (@(posedge clk) disable iff (!rst_n)
        door_open |-> !(move_up || move_down));

    a_r6_one_direction: assert property (@(posedge clk) disable iff (!rst_n)
        !(move_up && move_down));

    a_r7_fire_preempts: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_alarm && (state_q != ST_FIRE_SINK) && (state_q != ST_FIRE_DOOR))
        |=> (move_down && !door_open && !move_up));

    a_r8_descent_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FIRE_SINK && cur_floor > BASE_V) |=> state_q == ST_FIRE_SINK);

    a_r9_fire_door_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FIRE_DOOR && fire_alarm) |=> state_q == ST_FIRE_DOOR);

    a_r9_resume_rest: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FIRE_DOOR && !fire_alarm) |=> state_q == ST_REST);

    a_r5_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        dwell_cnt <= LIMIT);

    a_r5_entry_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DWELL && $past(state_q) != ST_DWELL) |-> dwell_cnt == '0);

    a_r5_release: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DWELL && !fire_alarm && dwell_cnt == LIMIT) |=> state_q == ST_REST);

    a_r2_dwell_flag: assert property (@(posedge clk) disable iff (!rst_n)
        dwell_start |-> (door_open && state_q == ST_DWELL));
endmodule

bind lift_car_ctrl lift_car_ctrl_chk #(
    .FLOOR_W   (FLOOR_W),
    .DWELL_SECS(DWELL_SECS),
    .BASE_FLOOR(BASE_FLOOR)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cur_floor  (cur_floor),
    .fire_alarm (fire_alarm),
    .move_up    (move_up),
    .move_down  (move_down),
    .door_open  (door_open),
    .dwell_start(dwell_start),
    .state_q    (state_q),
    .dwell_cnt  (dwell_cnt)
);

// File: tb/lift_car_ctrl_tb_top.sv
`timescale 1ns/1ps
module lift_car_ctrl_tb_top;
    localparam int FW = 4;
    localparam int DW = 10;

    // bench model state codes
    localparam int M_REST = 0, M_RISE = 1, M_SINK = 2, M_DWELL = 3,
                   M_FSINK = 4, M_FDOOR = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [FW-1:0] req_floor = '0;
    logic [FW-1:0] cur_floor = 4'd1;
    logic          fire_alarm = 1'b0;
    logic          sec_tick = 1'b0;
    logic          move_up, move_down, door_open, dwell_start;

    int n_checks = 0;
    int n_errors = 0;
    int m_state  = M_REST;
    int m_cnt    = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    lift_car_ctrl #(.FLOOR_W(FW), .DWELL_SECS(DW), .BASE_FLOOR(1)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_floor(req_floor), .cur_floor(cur_floor),
        .fire_alarm(fire_alarm), .sec_tick(sec_tick), .move_up(move_up),
        .move_down(move_down), .door_open(door_open), .dwell_start(dwell_start)
    );

    function automatic logic [3:0] outs_of(input int s);
        case (s)
            M_REST:  return 4'b0010;
            M_RISE:  return 4'b1000;
            M_SINK:  return 4'b0100;
            M_DWELL: return 4'b0011;
            M_FSINK: return 4'b0100;
            M_FDOOR: return 4'b0010;
            default: return 4'b0000;
        endcase
    endfunction

    function automatic int next_of(input int s, input int cnt, input int rq,
                                   input int fl, input bit fi);
        if (fi && s < M_FSINK) return M_FSINK;
        case (s)
            M_REST:  return (rq > fl) ? M_RISE : ((rq < fl) ? M_SINK : M_REST);
            M_RISE:  return (rq > fl) ? M_RISE : M_DWELL;
            M_SINK:  return (rq < fl) ? M_SINK : M_DWELL;
            M_DWELL: return (cnt >= DW) ? M_REST : M_DWELL;
            M_FSINK: return (fl > 1) ? M_FSINK : M_FDOOR;
            default: return fi ? M_FDOOR : M_REST;
        endcase
    endfunction

    function automatic string tag_of(input int s);
        case (s)
            M_REST:  return "R3";
            M_RISE:  return "R4";
            M_SINK:  return "R4";
            M_DWELL: return "R5";
            M_FSINK: return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic check(input string tag, input logic [3:0] exp);
        logic [3:0] got;
        got = {move_up, move_down, door_open, dwell_start};
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s: outputs %b expected %b at %0t", tag, got, exp, $time);
        end
    endtask

    // drive after a falling edge, advance model at the rising edge, return at next falling edge
    task automatic step(input int rq, input int fl, input bit fi, input bit tk);
        int nxt;
        req_floor  = FW'(rq);
        cur_floor  = FW'(fl);
        fire_alarm = fi;
        sec_tick   = tk;
        @(posedge clk);
        nxt = next_of(m_state, m_cnt, rq, fl, fi);
        if (m_state == M_DWELL) begin
            if (tk && m_cnt < DW) m_cnt = m_cnt + 1;
        end else begin
            m_cnt = 0;
        end
        m_state = nxt;
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: run did not complete, got timeout expected finish");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        int seed;
        int rq, fl;
        bit fi, tk;
        seed = $urandom(32'h5EED_1234);
        repeat (3) @(negedge clk);
        check("R1", 4'b0010);               // reset outputs while held
        rst_n = 1'b1;
        step(1, 1, 0, 0);
        check("R1", 4'b0010);               // equal target stays in REST (also R3)

        // ticks outside DWELL must not pre-load the counter (R5)
        for (int i = 0; i < 12; i++) step(3, 3, 0, 1);
        check("R5", 4'b0010);

        // rise from 1 to 4 (R3, R2)
        step(4, 1, 0, 0);
        check("R3", 4'b1000);
        step(4, 2, 0, 0);
        step(4, 3, 0, 0);
        check("R4", 4'b1000);
        step(4, 4, 0, 0);
        check("R4", 4'b0011);               // arrival -> DWELL
        for (int i = 0; i < DW - 1; i++) step(4, 4, 0, 1);
        check("R5", 4'b0011);               // nine ticks: still dwelling
        step(4, 4, 0, 1);
        check("R5", 4'b0011);               // tenth tick counted at this edge
        step(4, 4, 0, 0);
        check("R5", 4'b0010);               // release to REST

        // sink from 4 to 2 (R3, R4)
        step(2, 4, 0, 0);
        check("R3", 4'b0100);
        step(2, 2, 0, 0);
        check("R4", 4'b0011);
        // second dwell: counter cleared again, gaps between ticks
        for (int i = 0; i < DW - 1; i++) begin
            step(2, 2, 0, 1);
            step(2, 2, 0, 0);
        end
        check("R5", 4'b0011);
        step(2, 2, 0, 1);
        step(2, 2, 0, 0);
        check("R5", 4'b0010);

        // fire during rise, dropped mid-descent (R7, R8)
        step(6, 2, 0, 0);
        check("R2", 4'b1000);
        step(6, 3, 1, 0);
        check("R7", 4'b0100);
        step(6, 3, 0, 0);
        check("R8", 4'b0100);               // alarm gone, still descending
        step(6, 2, 0, 0);
        check("R8", 4'b0100);
        step(6, 1, 1, 0);
        check("R8", 4'b0010);               // base reached -> FIRE_DOOR
        step(6, 1, 1, 1);
        step(6, 1, 1, 0);
        check("R9", 4'b0010);               // held while alarm high
        step(6, 1, 0, 0);
        check("R9", 4'b0010);               // REST
        step(6, 1, 0, 0);
        check("R9", 4'b1000);               // normal service resumed

        // fire from DWELL with car already at base
        step(1, 2, 0, 0);
        step(1, 1, 0, 0);
        check("R2", 4'b0011);
        step(1, 1, 1, 1);
        check("R7", 4'b0100);               // fire wins over dwell
        step(1, 1, 0, 0);
        check("R8", 4'b0010);               // immediately to FIRE_DOOR
        step(1, 1, 0, 0);
        check("R9", 4'b0010);

        // constrained random against the bench model
        fi = 1'b0;
        fl = 1;
        for (int i = 0; i < 6000; i++) begin
            if ($urandom_range(99) < 20) fl = $urandom_range(1, 9);
            rq = ($urandom_range(99) < 40) ? fl : $urandom_range(1, 9);
            if ($urandom_range(99) < 2) fi = ~fi;
            tk = ($urandom_range(99) < 35);
            step(rq, fl, fi, tk);
            check(tag_of(m_state), outs_of(m_state));
            n_checks++;
            if (door_open && (move_up || move_down)) begin
                n_errors++;
                $display("FAIL R6: door %b up %b down %b expected door shut in motion",
                         door_open, move_up, move_down);
            end
        end
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule